// File: doc/BRIEF.md
# Quad-Capable SPI Master Engine

This block is a master-side serial engine that moves one 8-bit frame per request. It works in two data modes. In single mode one line carries data out (data line 0) and another carries data in (data line 1). In quad mode, which is allowed only while master operation is selected, all four data lines (0 to 3) carry a nibble per SCK cycle in one direction chosen per frame. The engine drives SCK and an active-low chip select. The SCK idle level and the sampling edge are programmable, and so is the bit order.

A byte enters on a valid/ready port. A transfer is accepted on the cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low for the whole frame, so the upstream source has to hold or retry its byte, and a `tx_valid` raised during a frame has no effect. The receive side has no back-pressure. `rx_valid` pulses for one cycle at frame end, and `rx_data` keeps that value until the next accepted transfer. The configuration inputs are static. They are captured at acceptance and have no effect on a frame already in progress.

The data pins are split into `io_out`, `io_oe` and `io_in` so that pad cells outside the block can build bidirectional lines from them.

Top module: `spi_quad_master`

## Requirements
- R1: After reset, `cs_n` is 1, `busy` and `rx_valid` are 0, `tx_ready` is 1, `rx_data` is 0 and `sck` equals `cfg_cpol`.
- R2: A transfer starts on the cycle `tx_valid && tx_ready` holds. On the next cycle `busy` is 1 and `cs_n` is 0. `tx_ready` stays 0 while busy, and a `tx_valid` pulse during a frame starts no second frame.
- R3: The half-period H equals `cfg_half_div`, with 0 treated as 1, in system clocks. The first SCK edge comes H cycles after `cs_n` falls. Consecutive edges are H cycles apart. `cs_n` rises H cycles after the last edge.
- R4: While no frame runs, `sck` equals `cfg_cpol` (0 means idle low, 1 means idle high).
- R5: With `cfg_cpha`=0, data is sampled on the first SCK edge of each bit time and is valid before it. With `cfg_cpha`=1, data changes on the first edge and is sampled on the second.
- R6: Single mode uses 8 SCK cycles. Transmit data goes out on `io_out[0]` with `io_oe[0]`=1, and receive data is sampled on `io_in[1]` with `io_oe[1]`=0. `cfg_lsb_first`=1 sends and assembles bit 0 first; 0 sends bit 7 first.
- R7: Quad mode is active when `cfg_master` and `cfg_quad_en` are both 1. It uses 2 SCK cycles, and line k carries nibble bit k. `cfg_lsb_first`=1 moves bits 3:0 first; 0 moves bits 7:4 first.
- R8: In quad mode, `cfg_quad_rx`=1 sets `io_oe`=4'b0000 and assembles the received nibbles from `io_in[3:0]`. `cfg_quad_rx`=0 sets `io_oe`=4'b1111.
- R9: With `cfg_master`=0, `cfg_quad_en` is ignored and the frame runs exactly as in single mode.
- R10: In single mode, `io_oe[3:2]` equals `{cfg_io23_hold, cfg_io23_hold}` and `io_out[3:2]` is 2'b11.
- R11: Mode, order, phase, polarity and divider are taken from their values at acceptance. Changes to them during a frame do not alter it.
- R12: `rx_valid` is high for exactly one cycle, the one in which `cs_n` returns high. `rx_data` holds the received byte from then until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half_div | input | DIV_W | SCK half-period in system clocks (0 acts as 1) |
| cfg_master | input | 1 | Master operation selected; gates quad mode |
| cfg_quad_en | input | 1 | Quad data mode request |
| cfg_quad_rx | input | 1 | Quad direction: 1 receive, 0 transmit |
| cfg_io23_hold | input | 1 | In single mode, drive lines 2 and 3 high |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Sampling edge: 0 first, 1 second |
| cfg_lsb_first | input | 1 | Bit order select |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine can accept a byte |
| tx_data | input | DATA_W | Byte to send |
| rx_valid | output | 1 | One-cycle frame-complete pulse |
| rx_data | output | DATA_W | Received byte |
| busy | output | 1 | Frame in progress |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Output value of data lines 0 to 3 |
| io_oe | output | 4 | Output enable of data lines 0 to 3 |
| io_in | input | 4 | Input value of data lines 0 to 3 |

## Verification
The bench acts as a slave at the pins, and each frame is checked over every polarity and phase, both bit orders, three half-period settings and five data-mode setups.

- A drive/sample mix-up between phases would capture the neighbouring bit, so transmitted and received bytes come back shifted.
- A wrong order or nibble lane mapping shows up as a reversed or swapped byte.
- An off-by-one in the divider or in the chip-select lead or trail shows up as a wrong edge spacing.
- A quad request honoured without master mode would cut the frame to four edges and drive all lanes.

Two targeted frames cover the busy-strobe case and the mid-frame configuration change. A design that accepted the strobe would start a second frame, and one that did not latch its configuration would switch order or mode partway through.

// File: rtl/spi_qm_pkg.sv
package spi_qm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic master;
    logic quad_en;
    logic quad_rx;
    logic io23_hold;
    logic cpol;
    logic cpha;
    logic lsb_first;
  } link_cfg_t;

endpackage

// File: rtl/spi_qm_halfclk.sv
// Half-period tick generator: one tick every max(half_div,1) cycles while run is high.
module spi_qm_halfclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (half_div == '0) ? '0 : half_div - DIV_W'(1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || cnt == lim) cnt <= '0;
    else                        cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_qm_seq.sv
// Frame sequencer: chip-select lead, SCK edges, chip-select trail.
module spi_qm_seq import spi_qm_pkg::*; #(
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic [EW-1:0] last_edge,
  output logic          busy,
  output logic          cs_n,
  output logic          sck_phase,
  output logic          edge_ev,
  output logic          done,
  output logic [EW-1:0] edge_idx
);
  seq_state_t st;

  assign busy    = (st != ST_IDLE);
  assign edge_ev = (st == ST_RUN) && tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cs_n      <= 1'b1;
      sck_phase <= 1'b0;
      edge_idx  <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st        <= ST_RUN;
          cs_n      <= 1'b0;
          sck_phase <= 1'b0;
          edge_idx  <= '0;
        end
        ST_RUN: if (tick) begin
          sck_phase <= ~sck_phase;
          edge_idx  <= edge_idx + EW'(1);
          if (edge_idx == last_edge) st <= ST_TAIL;
        end
        ST_TAIL: if (tick) begin
          st   <= ST_IDLE;
          cs_n <= 1'b1;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_qm_lanes.sv
// Lane datapath: picks the outgoing bit/nibble and assembles the incoming byte.
module spi_qm_lanes #(
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [DATA_W-1:0]               tx_byte,
  input  logic                            quad,
  input  logic                            lsb_first,
  input  logic                            cpha,
  input  logic                            edge_ev,
  input  logic [$clog2(2*DATA_W)-1:0]     edge_idx,
  input  logic [$clog2(2*DATA_W)-1:0]     last_edge,
  input  logic [3:0]                      io_in,
  output logic [3:0]                      tx_unit,
  output logic [DATA_W-1:0]               rx_byte
);
  localparam int NQ = DATA_W / 4;
  localparam int UW = $clog2(DATA_W);
  localparam int EW = UW + 1;
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

  logic [DATA_W-1:0] tx_q;
  logic [UW-1:0]     u_drv, u_smp, s_drv, s_smp;
  logic [QW-1:0]     q_drv, q_smp;
  logic [3:0]        nib [NQ];
  logic              adv, smp;

  genvar g;
  generate
    for (g = 0; g < NQ; g++) begin : g_nib
      assign nib[g] = tx_q[4*g +: 4];
    end
  endgenerate

  assign u_smp = edge_idx[EW-1:1];
  assign s_drv = lsb_first ? u_drv : UW'(DATA_W-1) - u_drv;
  assign s_smp = lsb_first ? u_smp : UW'(DATA_W-1) - u_smp;
  assign q_drv = lsb_first ? u_drv[QW-1:0] : QW'(NQ-1) - u_drv[QW-1:0];
  assign q_smp = lsb_first ? u_smp[QW-1:0] : QW'(NQ-1) - u_smp[QW-1:0];

  assign tx_unit = quad ? nib[q_drv] : {3'b000, tx_q[s_drv]};

  // first unit is preloaded; advance on the non-sampling edges
  assign adv = edge_ev && (cpha ? (!edge_idx[0] && edge_idx != '0)
                                : (edge_idx[0] && edge_idx != last_edge));
  assign smp = edge_ev && (edge_idx[0] == cpha);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q    <= '0;
      u_drv   <= '0;
      rx_byte <= '0;
    end else if (load) begin
      tx_q    <= tx_byte;
      u_drv   <= '0;
      rx_byte <= '0;
    end else begin
      if (adv) u_drv <= u_drv + UW'(1);
      if (smp) begin
        if (quad) begin
          for (int n = 0; n < NQ; n++)
            if (QW'(n) == q_smp) rx_byte[4*n +: 4] <= io_in;
        end else begin
          rx_byte[s_smp] <= io_in[1];
        end
      end
    end
  end
endmodule

// File: rtl/spi_quad_master.sv
module spi_quad_master import spi_qm_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic              cfg_master,
  input  logic              cfg_quad_en,
  input  logic              cfg_quad_rx,
  input  logic              cfg_io23_hold,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  localparam int NQ = DATA_W / 4;
  localparam int EW = $clog2(2*DATA_W);
  localparam logic [EW-1:0] LAST_SINGLE = EW'(2*DATA_W - 1);
  localparam logic [EW-1:0] LAST_QUAD   = EW'(2*NQ - 1);

  link_cfg_t        cfg_live, cfg_q, cfg_act;
  logic [DIV_W-1:0] div_q;
  logic             start, tick, sck_phase, edge_ev, quad_on, act_master;
  logic [EW-1:0]    edge_idx, last_edge;
  logic [3:0]       tx_unit;

  assign cfg_live = '{master: cfg_master, quad_en: cfg_quad_en, quad_rx: cfg_quad_rx,
                      io23_hold: cfg_io23_hold, cpol: cfg_cpol, cpha: cfg_cpha,
                      lsb_first: cfg_lsb_first};

  assign tx_ready = !busy;
  assign start    = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
    end else if (start) begin
      cfg_q <= cfg_live;
      div_q <= cfg_half_div;
    end
  end

  assign cfg_act    = busy ? cfg_q : cfg_live;
  assign act_master = cfg_act.master;
  assign quad_on    = cfg_act.master && cfg_act.quad_en;
  assign last_edge  = quad_on ? LAST_QUAD : LAST_SINGLE;

  spi_qm_halfclk #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_div(div_q), .tick(tick)
  );

  spi_qm_seq #(.EW(EW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .last_edge(last_edge),
    .busy(busy), .cs_n(cs_n), .sck_phase(sck_phase), .edge_ev(edge_ev),
    .done(rx_valid), .edge_idx(edge_idx)
  );

  spi_qm_lanes #(.DATA_W(DATA_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .load(start), .tx_byte(tx_data), .quad(quad_on),
    .lsb_first(cfg_act.lsb_first), .cpha(cfg_act.cpha), .edge_ev(edge_ev),
    .edge_idx(edge_idx), .last_edge(last_edge), .io_in(io_in),
    .tx_unit(tx_unit), .rx_byte(rx_data)
  );

  assign sck = sck_phase ^ cfg_act.cpol;

  always_comb begin
    if (quad_on) begin
      io_out = tx_unit;
      io_oe  = cfg_act.quad_rx ? 4'b0000 : 4'b1111;
    end else begin
      io_out = {2'b11, 1'b0, tx_unit[0]};
      io_oe  = {cfg_act.io23_hold, cfg_act.io23_hold, 1'b0, 1'b1};
    end
  end
endmodule

// File: rtl/spi_quad_master_chk.sv
module spi_quad_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cs_n,
  input logic              sck,
  input logic              cfg_cpol,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic [3:0]        io_oe,
  input logic              act_master
);
  // R2
  accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (busy && !cs_n));

  // R2
  idle_deselects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R4
  sck_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cfg_cpol));

  // R12
  done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!busy && cs_n));

  // R12
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_valid) |-> $stable(rx_data));

  // R9
  quad_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe[1] |-> act_master);
endmodule

bind spi_quad_master spi_quad_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .sck(sck),
  .cfg_cpol(cfg_cpol), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data), .io_oe(io_oe), .act_master(act_master)
);

// File: tb/spi_quad_master_bench.sv
module spi_quad_master_bench;
  localparam int DW = 8;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [VW-1:0] cfg_half_div;
  logic cfg_master, cfg_quad_en, cfg_quad_rx, cfg_io23_hold, cfg_cpol, cfg_cpha, cfg_lsb_first;
  logic tx_valid, tx_ready, rx_valid, busy, sck, cs_n;
  logic [DW-1:0] tx_data, rx_data;
  logic [3:0] io_out, io_oe, io_in;

  spi_quad_master #(.DATA_W(DW), .DIV_W(VW)) u_spi_quad_master (
    .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div), .cfg_master(cfg_master),
    .cfg_quad_en(cfg_quad_en), .cfg_quad_rx(cfg_quad_rx), .cfg_io23_hold(cfg_io23_hold),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // bench-side frame model
  bit f_on = 0, f_quad, f_qrx, f_hold, f_cpha, f_lsb, f_nomaster;
  int f_h, f_nu, f_edges, f_samp, f_last;
  logic [7:0] f_sl, f_cap;
  logic p_sck = 1'b0, p_cs = 1'b1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] slave_unit(input int k);
    int p;
    if (k >= f_nu) return 4'b0000;
    if (f_quad) begin
      p = f_lsb ? k : 1 - k;
      return f_sl[4*p +: 4];
    end
    p = f_lsb ? k : 7 - k;
    return {2'b00, f_sl[p], 1'b0};
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (f_on) begin
      if (p_cs && !cs_n) begin
        f_last = cyc; f_edges = 0; f_samp = 0; f_cap = '0;
      end else if (!cs_n && sck != p_sck) begin
        chk(cyc - f_last == f_h, "R3 edge spacing", cyc - f_last, f_h);
        f_last = cyc;
        if ((f_edges % 2) == int'(f_cpha) && f_samp < f_nu) begin
          if (f_quad) begin
            f_cap[4*(f_lsb ? f_samp : 1 - f_samp) +: 4] = io_out;
            chk(io_oe == (f_qrx ? 4'b0000 : 4'b1111), "R8 quad lane direction", io_oe, f_qrx ? 0 : 15);
          end else begin
            f_cap[f_lsb ? f_samp : 7 - f_samp] = io_out[0];
            chk(io_oe == {f_hold, f_hold, 2'b01},
                f_nomaster ? "R9 quad ignored without master" : "R10 single mode enables",
                io_oe, {f_hold, f_hold, 2'b01});
            if (f_hold) chk(io_out[3:2] == 2'b11, "R10 lines 2 and 3 high", io_out[3:2], 3);
          end
          f_samp++;
          io_in = slave_unit(f_samp);
        end
        f_edges++;
      end else if (!p_cs && cs_n) begin
        chk(cyc - f_last == f_h, "R3 trailing chip select", cyc - f_last, f_h);
      end
    end
    p_sck = sck;
    p_cs  = cs_n;
  end

  // special: 0 none, 1 strobe while busy, 2 change config mid-frame
  task automatic run_frame(input bit m, input bit qe, input bit qrx, input bit hold,
                           input bit cpol, input bit cpha, input bit lsb, input int dv,
                           input logic [7:0] txb, input logic [7:0] slb, input int special);
    int n;
    cfg_master = m; cfg_quad_en = qe; cfg_quad_rx = qrx; cfg_io23_hold = hold;
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_half_div = VW'(dv);
    f_quad = m && qe; f_qrx = qrx; f_hold = hold; f_cpha = cpha; f_lsb = lsb;
    f_nomaster = !m && qe;
    f_h = (dv == 0) ? 1 : dv; f_sl = slb; f_nu = f_quad ? 2 : 8;
    f_edges = 0; f_samp = 0; f_cap = '0;
    f_on = 1;
    io_in = slave_unit(0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R2 ready while idle", tx_ready, 1);
    chk(sck == cpol, "R4 idle level before frame", sck, cpol);
    tx_data = txb; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(busy && !cs_n, "R2 accept starts frame", {busy, cs_n}, 2);
    if (special == 1) begin
      repeat (3) @(negedge clk);
      chk(!tx_ready, "R2 ready low while busy", tx_ready, 0);
      tx_data = ~txb; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
    end
    if (special == 2) begin
      cfg_lsb_first = ~lsb; cfg_quad_en = ~qe; cfg_cpha = ~cpha; cfg_half_div = VW'(dv + 2);
    end
    n = 0;
    while (!rx_valid && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(rx_valid, "R12 done pulse", rx_valid, 1);
    chk(cs_n, "R12 done with chip select released", cs_n, 1);
    chk(f_edges == 2 * f_nu, f_quad ? "R7 quad edge count" : "R6 single edge count", f_edges, 2 * f_nu);
    if (!f_quad || f_qrx)
      chk(rx_data == slb, f_quad ? "R8 quad receive (R5 phase)" : "R6 single receive (R5 phase)", rx_data, slb);
    if (!(f_quad && f_qrx))
      chk(f_cap == txb, f_quad ? "R7 quad transmit (R5 phase)" : "R6 single transmit (R5 phase)", f_cap, txb);
    if (special == 2)
      chk(f_cap == txb && rx_data == slb, "R11 latched configuration", {f_cap, rx_data}, {txb, slb});
    chk(sck == cpol, "R4 idle level after frame", sck, cpol);
    @(negedge clk);
    chk(!rx_valid, "R12 one-cycle pulse", rx_valid, 0);
    if (!f_quad || f_qrx) chk(rx_data == slb, "R12 rx held", rx_data, slb);
    if (special == 1) begin
      repeat (10) begin
        @(negedge clk);
        chk(!busy && cs_n, "R2 strobe while busy ignored", {busy, cs_n}, 1);
      end
    end
    f_on = 0;
    cfg_cpha = cpha; cfg_quad_en = qe; cfg_lsb_first = lsb;
  endtask

  initial begin
    cfg_half_div = VW'(1); cfg_master = 1'b1; cfg_quad_en = 1'b0; cfg_quad_rx = 1'b0;
    cfg_io23_hold = 1'b0; cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
    tx_valid = 1'b0; tx_data = '0; io_in = 4'b0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset chip select", cs_n, 1);
    chk(!busy && tx_ready, "R1 reset idle handshake", {busy, tx_ready}, 1);
    chk(!rx_valid && rx_data == '0, "R1 reset receive side", {rx_valid, rx_data}, 0);
    chk(sck == 1'b1, "R1 reset sck at polarity", sck, 1);

    for (int cp = 0; cp < 4; cp++)
      for (int lsb = 0; lsb < 2; lsb++)
        for (int md = 0; md < 5; md++)
          for (int hs = 0; hs < 3; hs++) begin
            int idx;
            int dv;
            logic [7:0] txb, slb;
            idx = ((cp * 2 + lsb) * 5 + md) * 3 + hs;
            dv  = (hs == 0) ? 0 : ((hs == 1) ? 1 : 3);
            txb = 8'(8'h3C + idx * 37);
            slb = 8'(8'hA5 ^ (idx * 29));
            run_frame(md != 4, md >= 2, md == 3, (md == 1) || (md == 4),
                      cp[1], cp[0], lsb[0], dv, txb, slb, 0);
          end

    run_frame(1, 0, 0, 0, 0, 1, 0, 2, 8'h96, 8'h5A, 1);
    run_frame(1, 1, 0, 0, 1, 0, 1, 1, 8'hC3, 8'h3E, 2);
    run_frame(1, 0, 0, 1, 0, 1, 0, 2, 8'h81, 8'h7E, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule